// File: doc/BRIEF.md
# Network Flit Receive DMA

This block sits between the local output port of a network-on-chip router and the processor memory. Flits are 16 bits wide. They enter through a small flit FIFO. A receive sequencer then takes a header flit, a length flit and that many payload flits, and keeps the payload in a local packet buffer. When the last payload flit has arrived, the block raises its interrupt and reports the packet length. It then waits for the processor to supply a destination address and a word limit and to raise its start level.

The copy itself runs while the processor is held by the stall output. Each buffered flit goes into the low half of one 32-bit memory word, at consecutive word addresses. After the copy, the block waits for the start level to drop before it takes the next packet. A separate reload path, chosen by a level input, skips the handshake. It writes the payload of a burst straight from the FIFO to memory at the programmed address.

Top module: `nocrx_dma`

## Requirements
- R1: After reset, `irq`, `cpu_hold` and `wr_en` are 0, `rx_status` is 0 and `flit_ready` is 1.
- R2: In normal mode the first flit of a packet is discarded as a header. The next flit is the payload length N. `irq` stays 0 until the N-th payload flit has been taken and then rises.
- R3: While `irq` is 1, `rx_status` equals N zero-extended to 32 bits. `irq` and `rx_status` hold until `cfg_start` is seen high, and `irq` falls only after `cfg_start` was high.
- R4: A copy writes buffered flit i (in arrival order, from 0) to word address `cfg_addr + i`, with `wr_data = {16'h0000, flit}`.
- R5: The number of words copied is the smaller of `cfg_words` and the number of stored flits. `cpu_hold` is 1 in exactly the cycles in which a copy write is issued, and it is 0 in every other cycle.
- R6: The packet buffer holds BUF_DEPTH flits (default 16). With N > BUF_DEPTH, only the first BUF_DEPTH payload flits are stored. The rest are taken and dropped, and `rx_status` still reports N.
- R7: After a copy the block takes no new flit until `cfg_start` is low. A packet that arrives before then raises `irq` only after `cfg_start` falls.
- R8: `flit_ready` is 0 while the flit FIFO holds FIFO_DEPTH flits (default 16). No accepted flit is lost or reordered.
- R9: If `reload_en` is 1 when a header flit is taken, that flit is a wake-up flit. The next flit is a burst length M. The M following flits are each written, when taken, to `cfg_addr + j` as `{16'h0000, flit}`, with `irq` and `cpu_hold` at 0.
- R10: After a reload burst the block takes no flit until `reload_en` is 0. The next flit taken is then treated as a normal header.
- R11: A length flit of 0 raises `irq` with `rx_status` 0. The copy that follows writes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flit_valid | input | 1 | Router offers a flit |
| flit_data | input | 16 | Flit from router |
| flit_ready | output | 1 | Flit FIFO can accept |
| reload_en | input | 1 | Select raw reload path |
| cfg_start | input | 1 | Processor start level for a copy |
| cfg_addr | input | 32 | Destination word address |
| cfg_words | input | 32 | Word limit for a copy |
| irq | output | 1 | Packet buffered, waiting for start |
| cpu_hold | output | 1 | Stall to processor during copy |
| rx_status | output | 32 | Payload length of the pending packet |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 32 | Memory word address |
| wr_data | output | 32 | Memory write data |

## Verification
The main path is driven with a short packet, a packet longer than the buffer, an empty packet and a packet that overfills the FIFO while the block waits for the processor. Taken together, these separate the length counting and buffer truncation from FIFO back-pressure. A word limit below the packet length separates limit handling from length handling. A second packet is sent while the start level is still high, which checks that the flush wait really gates intake. The reload burst, followed by a flit pushed before the reload level drops, shows whether that flit is held and later treated as a normal header.

// File: rtl/nocrx_pkg.sv
// Shared widths and sequencer state encoding for the receive DMA.
package nocrx_pkg;
    localparam int FLIT_W = 16;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        ST_HDR,    // take header or wake-up flit
        ST_LEN,    // take payload length
        ST_PAY,    // collect payload into buffer
        ST_WAIT,   // interrupt raised, wait for start
        ST_COPY,   // copy buffer to memory, processor held
        ST_DONE,   // wait for start level to drop
        ST_RLEN,   // reload: take burst length
        ST_RSTR,   // reload: stream payload to memory
        ST_RDONE   // reload: wait for reload level to drop
    } rx_state_t;
endpackage

// File: rtl/nocrx_fifo.sv
// Flit FIFO with show-ahead output.
// Assumes DEPTH is a power of two; push is refused when full.
module nocrx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_pop
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          push, pop;

    assign in_ready  = (count != FULL);
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign push      = in_valid && in_ready;
    assign pop       = out_pop && out_valid;

    // Store an accepted flit.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= in_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);
    assert_pop_when_filled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_pop |-> out_valid);
endmodule

// File: rtl/nocrx_pbuf.sv
// Packet payload buffer: one write port, one asynchronous read port.
// Assumes indices are below DEPTH (the sequencer bounds them).
module nocrx_pbuf #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    // Write one payload flit.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/nocrx_seq.sv
// Receive sequencer: parses packets, runs the interrupt/start handshake,
// drives memory writes for both the buffered copy and the reload stream.
// Assumes cfg_* are stable while cfg_start is high.
module nocrx_seq
    import nocrx_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    localparam int IW       = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_valid,
    input  logic [FLIT_W-1:0] f_data,
    output logic              f_pop,
    input  logic              reload_en,
    input  logic              cfg_start,
    input  logic [WORD_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_words,
    output logic              b_wr,
    output logic [IW-1:0]     b_widx,
    output logic [IW-1:0]     b_ridx,
    input  logic [FLIT_W-1:0] b_rdata,
    output logic              irq,
    output logic              cpu_hold,
    output logic [WORD_W-1:0] rx_status,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);
    localparam logic [WORD_W-1:0] CAP = WORD_W'(BUF_DEPTH);

    rx_state_t         st;
    logic [FLIT_W-1:0] len, cnt;
    logic [WORD_W-1:0] base, cp_len, cp_cnt;
    logic [WORD_W-1:0] stored, limit;
    logic              taking;

    // Flits are consumed only in the parsing and streaming states.
    always_comb begin
        taking = (st == ST_HDR) || (st == ST_LEN) || (st == ST_PAY) ||
                 (st == ST_RLEN) || (st == ST_RSTR);
    end
    assign f_pop = taking && f_valid;

    // Stored flit count and the copy length granted by the processor.
    always_comb begin
        stored = ({16'h0000, len} > CAP) ? CAP : {16'h0000, len};
        limit  = (cfg_words < stored) ? cfg_words : stored;
    end

    assign b_wr   = (st == ST_PAY) && f_pop && ({16'h0000, cnt} < CAP);
    assign b_widx = cnt[IW-1:0];
    assign b_ridx = cp_cnt[IW-1:0];

    // State and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_HDR;
            len    <= '0;
            cnt    <= '0;
            base   <= '0;
            cp_len <= '0;
            cp_cnt <= '0;
        end else begin
            case (st)
                ST_HDR:  if (f_pop) st <= reload_en ? ST_RLEN : ST_LEN;
                ST_LEN:  if (f_pop) begin
                    len <= f_data;
                    cnt <= '0;
                    st  <= (f_data == '0) ? ST_WAIT : ST_PAY;
                end
                ST_PAY:  if (f_pop) begin
                    cnt <= cnt + 16'd1;
                    if (cnt + 16'd1 == len) st <= ST_WAIT;
                end
                ST_WAIT: if (cfg_start) begin
                    base   <= cfg_addr;
                    cp_len <= limit;
                    cp_cnt <= '0;
                    st     <= (limit == '0) ? ST_DONE : ST_COPY;
                end
                ST_COPY: begin
                    cp_cnt <= cp_cnt + 32'd1;
                    if (cp_cnt + 32'd1 == cp_len) st <= ST_DONE;
                end
                ST_DONE: if (!cfg_start) st <= ST_HDR;
                ST_RLEN: if (f_pop) begin
                    base <= cfg_addr;
                    len  <= f_data;
                    cnt  <= '0;
                    st   <= (f_data == '0) ? ST_RDONE : ST_RSTR;
                end
                ST_RSTR: if (f_pop) begin
                    cnt <= cnt + 16'd1;
                    if (cnt + 16'd1 == len) st <= ST_RDONE;
                end
                ST_RDONE: if (!reload_en) st <= ST_HDR;
                default: st <= ST_HDR;
            endcase
        end
    end

    // Handshake and memory-port outputs.
    always_comb begin
        irq       = (st == ST_WAIT);
        cpu_hold  = (st == ST_COPY);
        rx_status = irq ? {16'h0000, len} : '0;
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        if (st == ST_COPY) begin
            wr_en   = 1'b1;
            wr_addr = base + cp_cnt;
            wr_data = {16'h0000, b_rdata};
        end else if ((st == ST_RSTR) && f_pop) begin
            wr_en   = 1'b1;
            wr_addr = base + {16'h0000, cnt};
            wr_data = {16'h0000, f_data};
        end
    end

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && $past(rst_n)) |-> (wr_addr == $past(wr_addr) + 32'd1));
    assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cfg_start) |=> irq);
    assert_status_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq)) |-> $stable(rx_status));
    assert_irq_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(cfg_start));
    assert_done_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_DONE) && cfg_start) |=> !f_pop);
endmodule

// File: rtl/nocrx_dma.sv
// Top of the flit receive DMA: flit FIFO, payload buffer and sequencer.
// Assumes the memory write port accepts one word per cycle.
module nocrx_dma #(
    parameter int FIFO_DEPTH = 16,
    parameter int BUF_DEPTH  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flit_valid,
    input  logic [15:0] flit_data,
    output logic        flit_ready,
    input  logic        reload_en,
    input  logic        cfg_start,
    input  logic [31:0] cfg_addr,
    input  logic [31:0] cfg_words,
    output logic        irq,
    output logic        cpu_hold,
    output logic [31:0] rx_status,
    output logic        wr_en,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data
);
    import nocrx_pkg::*;
    localparam int IW = $clog2(BUF_DEPTH);

    logic              f_valid, f_pop, b_wr;
    logic [FLIT_W-1:0] f_data, b_rdata;
    logic [IW-1:0]     b_widx, b_ridx;

    nocrx_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .in_valid(flit_valid), .in_data(flit_data), .in_ready(flit_ready),
        .out_valid(f_valid), .out_data(f_data), .out_pop(f_pop)
    );

    nocrx_pbuf #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_pbuf (
        .clk(clk), .wr_en(b_wr), .wr_idx(b_widx), .wr_data(f_data),
        .rd_idx(b_ridx), .rd_data(b_rdata)
    );

    nocrx_seq #(.BUF_DEPTH(BUF_DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .f_valid(f_valid), .f_data(f_data), .f_pop(f_pop),
        .reload_en(reload_en), .cfg_start(cfg_start),
        .cfg_addr(cfg_addr), .cfg_words(cfg_words),
        .b_wr(b_wr), .b_widx(b_widx), .b_ridx(b_ridx), .b_rdata(b_rdata),
        .irq(irq), .cpu_hold(cpu_hold), .rx_status(rx_status),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );
endmodule

// File: tb/nocrx_dma_bench.sv
// Bench: reference expectations kept as a write queue, compared every clock.
module nocrx_dma_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        flit_valid = 0;
    logic [15:0] flit_data = 0;
    logic        flit_ready;
    logic        reload_en = 0;
    logic        cfg_start = 0;
    logic [31:0] cfg_addr = 0;
    logic [31:0] cfg_words = 0;
    logic        irq, cpu_hold, wr_en;
    logic [31:0] rx_status, wr_addr, wr_data;

    int checks = 0;
    int fails = 0;
    int writes = 0;
    int hold_cycles = 0;
    bit exp_hold = 1;
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];

    always #2 clk = ~clk;   // 250 MHz

    nocrx_dma u_nocrx_dma (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_data(flit_data),
        .flit_ready(flit_ready), .reload_en(reload_en), .cfg_start(cfg_start),
        .cfg_addr(cfg_addr), .cfg_words(cfg_words), .irq(irq), .cpu_hold(cpu_hold),
        .rx_status(rx_status), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the memory port against the expected queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_hold) hold_cycles++;
            if (wr_en) begin
                writes++;
                check("R5 hold during write", {31'b0, cpu_hold}, {31'b0, exp_hold});
                if (q_addr.size() == 0) begin
                    check("R4/R5 unexpected write", wr_addr, 32'hFFFF_FFFF);
                end else begin
                    check("R4 write address", wr_addr, q_addr.pop_front());
                    check("R4 write data", wr_data, q_data.pop_front());
                end
            end else if (cpu_hold) begin
                check("R5 hold without write", 32'd1, 32'd0);
            end
        end
    end

    task automatic push(input logic [15:0] v);
        @(negedge clk);
        flit_valid = 1;
        flit_data  = v;
        while (!flit_ready) @(negedge clk);
        @(posedge clk);
        #1;
        flit_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq(input string req);
        int t = 0;
        while (!irq && t < 200) begin @(negedge clk); t++; end
        check(req, {31'b0, irq}, 32'd1);
    endtask

    // Expect words from a base address, flit values given as start + i.
    task automatic expect_words(input logic [31:0] a, input logic [15:0] v0, input int n);
        for (int i = 0; i < n; i++) begin
            q_addr.push_back(a + 32'(i));
            q_data.push_back({16'h0000, v0 + 16'(i)});
        end
    endtask

    // Run one copy: start, wait for the hold to end, check counts.
    task automatic do_copy(input string req, input logic [31:0] a, input logic [31:0] lim,
                           input int nexp);
        int w0;
        w0 = writes;
        hold_cycles = 0;
        @(negedge clk);
        cfg_addr = a; cfg_words = lim; cfg_start = 1;
        idle(nexp + 4);
        check({req, " words written"}, 32'(writes - w0), 32'(nexp));
        check({req, " hold cycles"}, 32'(hold_cycles), 32'(nexp));
        check({req, " queue drained"}, 32'(q_addr.size()), 32'd0);
    endtask

    task automatic packet(input logic [15:0] n, input logic [15:0] v0);
        push(16'hABCD);
        push(n);
        for (int i = 0; i < int'(n); i++) push(v0 + 16'(i));
    endtask

    initial begin
        idle(3);
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 hold", {31'b0, cpu_hold}, 0);
        check("R1 wr_en", {31'b0, wr_en}, 0);
        check("R1 status", rx_status, 0);
        check("R1 ready", {31'b0, flit_ready}, 1);
        rst_n = 1;

        // R2 irq only after the last payload flit
        push(16'hA000); push(16'd5);
        for (int i = 0; i < 4; i++) push(16'h1110 + 16'(i));
        idle(10);
        check("R2 no irq before last flit", {31'b0, irq}, 0);
        push(16'h1114);
        wait_irq("R2 irq after last flit");
        check("R3 status length", rx_status, 32'd5);
        idle(6);
        check("R3 irq held", {31'b0, irq}, 1);
        check("R3 status held", rx_status, 32'd5);
        expect_words(32'h100, 16'h1110, 5);
        do_copy("R4", 32'h100, 32'd8, 5);

        // R7 next packet held while start stays high
        packet(16'd2, 16'h2220);
        idle(30);
        check("R7 no irq while start high", {31'b0, irq}, 0);
        cfg_start = 0;
        wait_irq("R7 irq after start drops");
        check("R7 status", rx_status, 32'd2);
        expect_words(32'h200, 16'h2220, 1);
        do_copy("R5 word limit", 32'h200, 32'd1, 1);
        cfg_start = 0;

        // R6 packet longer than the buffer
        packet(16'd20, 16'h3000);
        wait_irq("R6 irq");
        check("R6 status reports full length", rx_status, 32'd20);
        expect_words(32'h300, 16'h3000, 16);
        do_copy("R6 truncated copy", 32'h300, 32'd100, 16);
        cfg_start = 0;

        // R8 FIFO fills while waiting for start
        packet(16'd1, 16'h4000);
        wait_irq("R8 irq first packet");
        packet(16'd14, 16'h5000);
        idle(2);
        check("R8 ready low when full", {31'b0, flit_ready}, 0);
        expect_words(32'h400, 16'h4000, 1);
        do_copy("R8 first copy", 32'h400, 32'd1, 1);
        cfg_start = 0;
        wait_irq("R8 held packet irq");
        check("R8 held packet status", rx_status, 32'd14);
        expect_words(32'h500, 16'h5000, 14);
        do_copy("R8 no loss", 32'h500, 32'd14, 14);
        cfg_start = 0;

        // R11 empty packet
        push(16'hABCD); push(16'd0);
        wait_irq("R11 irq empty packet");
        check("R11 status zero", rx_status, 32'd0);
        do_copy("R11 no write", 32'h600, 32'd5, 0);
        cfg_start = 0;

        // R9 reload burst straight to memory
        idle(3);
        reload_en = 1;
        exp_hold = 0;
        cfg_addr = 32'h800;
        push(16'h0001); push(16'd3);
        expect_words(32'h800, 16'h7000, 3);
        for (int i = 0; i < 3; i++) push(16'h7000 + 16'(i));
        idle(4);
        check("R9 reload writes drained", 32'(q_addr.size()), 32'd0);
        check("R9 no irq", {31'b0, irq}, 0);

        // R10 flit held until reload level drops, then a header
        begin
            int w0;
            w0 = writes;
            push(16'hBEEF);
            idle(10);
            check("R10 flit not consumed", 32'(writes - w0), 32'd0);
        end
        exp_hold = 1;
        reload_en = 0;
        push(16'd1); push(16'h9999);
        wait_irq("R10 held flit taken as header");
        check("R10 status", rx_status, 32'd1);
        expect_words(32'h900, 16'h9999, 1);
        do_copy("R10 copy", 32'h900, 32'd1, 1);
        cfg_start = 0;
        idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule